// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit timer channel that advances once for every cycle on which a count-enable tick is asserted. A load strobe delivers an initial count, a three-bit operating mode and a decimal-format flag in one cycle. From then on the channel produces one of six output waveforms on `out_o`: terminal flag, one-shot, rate pulse, square wave, software strobe and triggered strobe. The gate input either pauses counting or retriggers it, depending on the mode. The present count value is always visible on `count_o`, so a separate capture stage can sample it.

Inside, the channel keeps an elapsed-tick counter, a phase counter and a doubled-phase counter, and derives the output and the visible count from them. The output and the visible count are registered from the next state. A load therefore moves both to their new values on one clock edge, and no intermediate value can appear on either. The decimal flag is held and reported back, but counting is always binary.

Top module: `pit_channel`

## Requirements
- R1: After reset `out_o` is 0, `count_o` is 0 and `mode_o` is 0. Ticks and gate activity before the first load leave `out_o` and `count_o` at 0.
- R2: A loaded count of 0 acts as a period of 65536 ticks. In the terminal-flag mode (code 0) the output rises exactly 65536 advancing ticks after the load, and `count_o` reads 0 directly after the load.
- R3: Mode code 0 (terminal flag): `out_o` is 0 until the number of advancing ticks since the load equals the count N. It then goes to 1 and stays 1 until the next load.
- R4: Mode code 1 (one-shot): `out_o` is 1 while fewer than N ticks have elapsed since the load or since the last retrigger, and 0 after that.
- R5: Mode code 2 (rate): `out_o` is 1 only when the elapsed ticks d are a non-zero multiple of N. It is 0 in the cycle after a load, and `count_o` reads N − (d mod N).
- R6: Mode code 3 (square wave): `out_o` is 1 when (d mod N) < (N+1)/2 and 0 otherwise. `count_o` reads N − (2d mod N), so it steps down by two on each tick.
- R7: Mode codes 4 and 5 (strobes): `out_o` is 1 only while exactly N ticks have elapsed. An advancing tick during the pulse ends it.
- R8: In mode codes 0 and 4, a tick arriving while the gate is low is ignored: `count_o` and `out_o` hold their values.
- R9: In mode codes 1, 2, 3 and 5, a rising gate edge (gate 1 now, 0 in the previous cycle) resets the elapsed ticks to 0. It takes precedence over a tick in the same cycle. The gate level does not pause counting in these modes.
- R10: In mode codes 0, 1, 4 and 5, `count_o` reads (N − d) mod 65536, so it wraps from 0 to 0xFFFF and keeps counting down.
- R11: A load with mode code 6 acts as code 2 and a load with code 7 acts as code 3. `mode_o` reports the aliased code.
- R12: A load resets the elapsed ticks to 0 and takes precedence over a tick or a gate edge in the same cycle. In every mode `count_o` equals the loaded value one cycle later.
- R13: The decimal-format flag that arrives with a load is reported unchanged on `bcd_o` until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count enable; one tick per asserted cycle |
| gate_i | input | 1 | Gate level |
| load_valid_i | input | 1 | Load strobe for count, mode and flag |
| load_count_i | input | 16 | Initial count; 0 means 65536 |
| load_mode_i | input | 3 | Operating mode code, 0 to 7 |
| load_bcd_i | input | 1 | Decimal-format flag, stored only |
| out_o | output | 1 | Channel output waveform |
| count_o | output | 16 | Present count value |
| mode_o | output | 3 | Active mode after aliasing |
| bcd_o | output | 1 | Stored decimal-format flag |

## Verification
Every result of this block is due on the clock edge that samples the stimulus: a tick, a gate edge or a load changes `out_o`, `count_o`, `mode_o` and `bcd_o` at that edge. No further pipeline stage follows it. The bench drives its inputs at the falling edge. It advances a behavioural elapsed-tick model right after the rising edge, and compares all four outputs at the next falling edge, so each comparison falls in the cycle its result is due. The gate edge is computed in the model from the previous cycle's gate level, the same way the design sees it.

// File: rtl/pit_chan_pkg.sv
package pit_chan_pkg;

    typedef enum logic [2:0] {
        M_TERM     = 3'd0,
        M_ONESHOT  = 3'd1,
        M_RATE     = 3'd2,
        M_SQUARE   = 3'd3,
        M_SWSTROBE = 3'd4,
        M_HWSTROBE = 3'd5
    } pit_mode_e;

    // codes 6 and 7 fold onto the rate and square-wave modes
    function automatic pit_mode_e fold_mode(input logic [2:0] raw);
        case (raw)
            3'd6:    return M_RATE;
            3'd7:    return M_SQUARE;
            default: return pit_mode_e'(raw);
        endcase
    endfunction

    // gate level pauses counting
    function automatic logic gate_pauses(input pit_mode_e m);
        return (m == M_TERM) || (m == M_SWSTROBE);
    endfunction

    // rising gate edge restarts the period
    function automatic logic gate_retriggers(input pit_mode_e m);
        return (m == M_ONESHOT) || (m == M_RATE) ||
               (m == M_SQUARE)  || (m == M_HWSTROBE);
    endfunction

    // visible count runs down and wraps
    function automatic logic count_wraps(input pit_mode_e m);
        return (m == M_TERM) || (m == M_ONESHOT) ||
               (m == M_SWSTROBE) || (m == M_HWSTROBE);
    endfunction

endpackage

// File: rtl/pit_gate_edge.sv
module pit_gate_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic gate_i,
    output logic rise_o
);
    logic gate_d, gate_q;

    always_comb begin
        gate_d = gate_i;
        rise_o = gate_i & ~gate_q;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) gate_q <= 1'b0;
        else         gate_q <= gate_d;
    end
endmodule

// File: rtl/pit_advance.sv
module pit_advance #(
    parameter int CW = 16,
    localparam int NW = CW + 1,
    localparam int EW = CW + 2
) (
    input  logic [NW-1:0] reload_i,
    input  logic [EW-1:0] el_i,
    input  logic [NW-1:0] ph_i,
    input  logic [NW-1:0] dbl_i,
    input  logic [CW-1:0] cnt_i,
    output logic [EW-1:0] el_o,
    output logic [NW-1:0] ph_o,
    output logic [NW-1:0] dbl_o,
    output logic [CW-1:0] cnt_o
);
    logic [NW-1:0] ph_inc;
    logic [EW-1:0] rl_ext, dbl_sum, dbl_once, dbl_twice;

    always_comb begin
        rl_ext = EW'(reload_i);
        // elapsed ticks saturate one past the period: enough to tell <, == and >
        el_o   = (el_i > rl_ext) ? el_i : el_i + EW'(1);
        ph_inc = ph_i + NW'(1);
        ph_o   = (ph_inc == reload_i) ? '0 : ph_inc;
        // 2d mod N; a period of 1 needs a second subtraction
        dbl_sum   = EW'(dbl_i) + EW'(2);
        dbl_once  = (dbl_sum  >= rl_ext) ? dbl_sum  - rl_ext : dbl_sum;
        dbl_twice = (dbl_once >= rl_ext) ? dbl_once - rl_ext : dbl_once;
        dbl_o     = NW'(dbl_twice);
        cnt_o     = cnt_i - CW'(1);
    end
endmodule

// File: rtl/pit_out_decode.sv
module pit_out_decode
    import pit_chan_pkg::*;
#(
    parameter int CW = 16,
    localparam int NW = CW + 1,
    localparam int EW = CW + 2
) (
    input  logic          armed_i,
    input  pit_mode_e     mode_i,
    input  logic [NW-1:0] reload_i,
    input  logic [EW-1:0] el_i,
    input  logic [NW-1:0] ph_i,
    input  logic [NW-1:0] dbl_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          started_i,
    output logic          out_o,
    output logic [CW-1:0] count_o
);
    logic [EW-1:0] rl_ext, half;

    always_comb begin
        rl_ext  = EW'(reload_i);
        half    = (rl_ext + EW'(1)) >> 1;
        out_o   = 1'b0;
        count_o = '0;
        if (armed_i) begin
            case (mode_i)
                M_TERM:    out_o = (el_i >= rl_ext);
                M_ONESHOT: out_o = (el_i <  rl_ext);
                M_RATE:    out_o = started_i && (ph_i == '0);
                M_SQUARE:  out_o = (EW'(ph_i) < half);
                default:   out_o = (el_i == rl_ext);
            endcase
            case (mode_i)
                M_RATE:   count_o = CW'(reload_i - ph_i);
                M_SQUARE: count_o = CW'(reload_i - dbl_i);
                default:  count_o = cnt_i;
            endcase
        end
    end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_chan_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          gate_i,
    input  logic          load_valid_i,
    input  logic [CW-1:0] load_count_i,
    input  logic [2:0]    load_mode_i,
    input  logic          load_bcd_i,
    output logic          out_o,
    output logic [CW-1:0] count_o,
    output logic [2:0]    mode_o,
    output logic          bcd_o
);
    localparam int NW = CW + 1;
    localparam int EW = CW + 2;

    typedef struct packed {
        logic          armed;
        pit_mode_e     mode;
        logic          bcd;
        logic [NW-1:0] reload;
        logic [EW-1:0] el;
        logic [NW-1:0] ph;
        logic [NW-1:0] dbl;
        logic [CW-1:0] cnt;
        logic          started;
    } chan_st_t;

    chan_st_t      st_d, st_q;
    logic          out_d, out_q;
    logic [CW-1:0] cval_d, cval_q;
    logic          rise_w, restart_w, adv_w;
    logic [EW-1:0] el_n;
    logic [NW-1:0] ph_n, dbl_n, load_n;
    logic [CW-1:0] cnt_n;

    pit_gate_edge u_gate (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .gate_i (gate_i),
        .rise_o (rise_w)
    );

    pit_advance #(.CW(CW)) u_adv (
        .reload_i (st_q.reload),
        .el_i     (st_q.el),
        .ph_i     (st_q.ph),
        .dbl_i    (st_q.dbl),
        .cnt_i    (st_q.cnt),
        .el_o     (el_n),
        .ph_o     (ph_n),
        .dbl_o    (dbl_n),
        .cnt_o    (cnt_n)
    );

    always_comb begin
        load_n    = (load_count_i == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, load_count_i};
        st_d      = st_q;
        restart_w = 1'b0;
        adv_w     = 1'b0;
        if (load_valid_i) begin
            st_d.armed   = 1'b1;
            st_d.mode    = fold_mode(load_mode_i);
            st_d.bcd     = load_bcd_i;
            st_d.reload  = load_n;
            st_d.el      = '0;
            st_d.ph      = '0;
            st_d.dbl     = '0;
            st_d.cnt     = load_n[CW-1:0];
            st_d.started = 1'b0;
        end else if (st_q.armed) begin
            restart_w = rise_w && gate_retriggers(st_q.mode);
            adv_w     = !restart_w && tick_i &&
                        (!gate_pauses(st_q.mode) || gate_i);
            if (restart_w) begin
                st_d.el      = '0;
                st_d.ph      = '0;
                st_d.dbl     = '0;
                st_d.cnt     = st_q.reload[CW-1:0];
                st_d.started = 1'b0;
            end else if (adv_w) begin
                st_d.el      = el_n;
                st_d.ph      = ph_n;
                st_d.dbl     = dbl_n;
                st_d.cnt     = cnt_n;
                st_d.started = 1'b1;
            end
        end
    end

    // outputs are taken from the next state so a load switches them on one edge
    pit_out_decode #(.CW(CW)) u_dec (
        .armed_i   (st_d.armed),
        .mode_i    (st_d.mode),
        .reload_i  (st_d.reload),
        .el_i      (st_d.el),
        .ph_i      (st_d.ph),
        .dbl_i     (st_d.dbl),
        .cnt_i     (st_d.cnt),
        .started_i (st_d.started),
        .out_o     (out_d),
        .count_o   (cval_d)
    );

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q   <= '0;
            out_q  <= 1'b0;
            cval_q <= '0;
        end else begin
            st_q   <= st_d;
            out_q  <= out_d;
            cval_q <= cval_d;
        end
    end

    assign out_o   = out_q;
    assign count_o = cval_q;
    assign mode_o  = st_q.mode;
    assign bcd_o   = st_q.bcd;

    // R12
    load_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_valid_i |=> (count_o == $past(load_count_i)));

    // R5
    rate_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_valid_i && fold_mode(load_mode_i) == M_RATE) |=> !out_o);

    // R11
    alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_valid_i && load_mode_i == 3'd6) |=> (mode_o == 3'd2));

    // R3
    term_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 3'd0 && out_o && !load_valid_i) |=> out_o);

    // R7
    strobe_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((mode_o == 3'd4 || mode_o == 3'd5) && out_o && tick_i && !load_valid_i &&
         ((mode_o == 3'd5) ? !rise_w : gate_i)) |=> !out_o);

    // R10
    wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_w && count_wraps(st_q.mode) && count_o == '0) |=> (count_o == '1));
endmodule

// File: tb/pit_channel_tb.sv
module pit_channel_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, gate = 1'b0, ld = 1'b0, bcd_in = 1'b0;
    logic [15:0] ld_cnt = '0;
    logic [2:0]  ld_mode = '0;
    logic        out_w, bcd_w;
    logic [15:0] cnt_w;
    logic [2:0]  mode_w;

    int checks = 0, errors = 0;
    bit done = 0;

    // reference model state
    bit m_armed = 0, m_gprev = 0, m_bcd = 0;
    int m_mode = 0, m_n = 0, m_d = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pit_channel dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .gate_i(gate),
        .load_valid_i(ld), .load_count_i(ld_cnt), .load_mode_i(ld_mode),
        .load_bcd_i(bcd_in), .out_o(out_w), .count_o(cnt_w),
        .mode_o(mode_w), .bcd_o(bcd_w)
    );

    function automatic bit exp_out();
        if (!m_armed) return 0;
        case (m_mode)
            0: return m_d >= m_n;
            1: return m_d < m_n;
            2: return (m_d % m_n == 0) && (m_d != 0);
            3: return (m_d % m_n) < ((m_n + 1) / 2);
            default: return m_d == m_n;
        endcase
    endfunction

    function automatic int exp_cnt();
        if (!m_armed) return 0;
        case (m_mode)
            2: return (m_n - (m_d % m_n)) & 16'hFFFF;
            3: return (m_n - ((2 * m_d) % m_n)) & 16'hFFFF;
            default: return (m_n - m_d) & 16'hFFFF;
        endcase
    endfunction

    task automatic model_edge();
        bit rise;
        rise = gate && !m_gprev;
        m_gprev = gate;
        if (!rst_n) begin
            m_armed = 0; m_mode = 0; m_bcd = 0; m_gprev = 0;
        end else if (ld) begin
            m_armed = 1;
            m_mode  = (ld_mode == 6) ? 2 : (ld_mode == 7) ? 3 : int'(ld_mode);
            m_n     = (ld_cnt == 0) ? 65536 : int'(ld_cnt);
            m_d     = 0;
            m_bcd   = bcd_in;
        end else if (m_armed) begin
            if (rise && (m_mode == 1 || m_mode == 2 || m_mode == 3 || m_mode == 5))
                m_d = 0;
            else if (tick && (!(m_mode == 0 || m_mode == 4) || gate))
                m_d++;
        end
    endtask

    task automatic compare(input string tag);
        checks++;
        if (out_w !== exp_out()) begin
            errors++; $display("FAIL %s out actual %0b expected %0b", tag, out_w, exp_out());
        end
        checks++;
        if (int'(cnt_w) !== exp_cnt()) begin
            errors++; $display("FAIL %s count actual %0d expected %0d", tag, cnt_w, exp_cnt());
        end
        checks++;
        if (int'(mode_w) !== m_mode) begin
            errors++; $display("FAIL %s mode actual %0d expected %0d", tag, mode_w, m_mode);
        end
        checks++;
        if (bcd_w !== m_bcd) begin
            errors++; $display("FAIL %s bcd actual %0b expected %0b", tag, bcd_w, m_bcd);
        end
    endtask

    // one cycle: drive at falling edge, model at rising edge, compare at falling edge
    task automatic step(input string tag, input bit tk, input bit g);
        tick = tk; gate = g;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        ld = 0;
        compare(tag);
    endtask

    task automatic load(input string tag, input int md, input int n, input bit b,
                        input bit tk, input bit g);
        ld = 1; ld_mode = 3'(md); ld_cnt = 16'(n); bcd_in = b;
        step(tag, tk, g);
    endtask

    task automatic run(input string tag, input int cycles, input bit tk, input bit g);
        for (int i = 0; i < cycles; i++) step(tag, tk, g);
    endtask

    initial begin
        @(negedge clk);
        // R1 reset state
        for (int i = 0; i < 3; i++) begin @(posedge clk); model_edge(); @(negedge clk); compare("R1"); end
        rst_n = 1;
        run("R1", 4, 1, 1);
        step("R1", 1, 0);
        step("R1", 1, 1);
        // R3 terminal flag, R10 wrap past zero
        load("R3", 0, 5, 0, 0, 1);
        run("R3", 4, 1, 1);
        run("R3", 3, 1, 1);
        run("R10", 3, 1, 1);
        run("R3", 2, 0, 1);
        // R8 gate pauses in mode 0 and mode 4
        load("R8", 0, 4, 0, 0, 1);
        run("R8", 2, 1, 1);
        run("R8", 3, 1, 0);
        run("R8", 3, 1, 1);
        load("R8", 4, 3, 0, 0, 0);
        run("R8", 3, 1, 0);
        run("R8", 5, 1, 1);
        // R7 software strobe with sparse ticks
        load("R7", 4, 4, 0, 0, 1);
        for (int i = 0; i < 6; i++) begin step("R7", 1, 1); step("R7", 0, 1); end
        // R7 and R9 triggered strobe with gate restart
        load("R7", 5, 3, 0, 0, 0);
        run("R7", 2, 1, 0);
        step("R9", 1, 1);
        run("R7", 5, 1, 1);
        step("R9", 1, 0);
        step("R9", 1, 1);
        run("R7", 4, 1, 1);
        // R4 one-shot, R9 retrigger, R10 wrap
        load("R4", 1, 4, 0, 0, 0);
        run("R4", 6, 1, 0);
        step("R9", 1, 1);
        run("R4", 6, 1, 1);
        run("R10", 3, 1, 1);
        // R5 rate mode, sparse ticks, gate retrigger
        load("R5", 2, 3, 0, 0, 1);
        for (int i = 0; i < 5; i++) begin step("R5", 1, 1); step("R5", 0, 1); end
        step("R9", 0, 0);
        step("R9", 1, 1);
        run("R5", 5, 1, 1);
        load("R5", 2, 1, 0, 1, 1);
        run("R5", 3, 1, 1);
        // R6 square wave, odd and even periods
        load("R6", 3, 5, 0, 0, 1);
        run("R6", 12, 1, 1);
        load("R6", 3, 6, 0, 0, 1);
        run("R6", 13, 1, 1);
        step("R9", 1, 0);
        step("R9", 1, 1);
        run("R6", 4, 1, 1);
        // R11 aliasing of codes 6 and 7
        load("R11", 6, 4, 0, 0, 1);
        run("R11", 9, 1, 1);
        load("R11", 7, 4, 0, 0, 1);
        run("R11", 9, 1, 1);
        // R12 load wins over a tick and over a gate edge in the same cycle
        load("R12", 0, 6, 0, 0, 1);
        run("R12", 3, 1, 1);
        load("R12", 0, 9, 0, 1, 1);
        run("R12", 2, 1, 1);
        step("R12", 0, 0);
        load("R12", 5, 7, 0, 1, 1);
        run("R12", 3, 1, 1);
        // R13 decimal flag stored
        load("R13", 2, 10, 1, 0, 1);
        run("R13", 3, 1, 1);
        load("R13", 0, 10, 0, 0, 1);
        step("R13", 1, 1);
        // R2 count of zero means 65536 ticks
        load("R2", 0, 0, 0, 0, 1);
        run("R2", 65540, 1, 1);
        load("R2", 2, 0, 0, 0, 1);
        run("R2", 4, 1, 1);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule